// File: doc/BRIEF.md
# I2C Multi-Message Transfer Sequencer

This block drives a list of I2C messages through a byte-command I2C master. It does not toggle the bus wires itself. For each step it issues one command (start, stop, read, write, acknowledge mode, interrupt clear) together with a transmit byte. It then polls the master's status lines until the byte is finished. Message descriptors arrive one at a time on a take-on-accept port. Each descriptor carries a 10-bit slave address, a read flag, a 10-bit addressing flag, a no-start flag, a byte count and a last-message flag. Write payload is pulled from a byte stream, and received bytes are pushed out on a second byte stream.

The sequencer builds the address bytes, including the two-phase form for 10-bit slaves. It picks ACK or NACK for each read byte and places repeated STARTs between messages. Messages may also be chained without a new address. A transfer ends with a STOP followed by an interrupt-clear command. The block then raises `done_o` with an error code, and both hold until the next accepted `start_i`. An inactivity timer aborts a transfer whose master stops responding.

Top module: `i2c_msg_sequencer`

## Requirements
- R1: After reset the block is idle: `busy_o`=0, `done_o`=0, `err_o`=0 (none) and `cmd_valid_o`=0.
- R2: After `start_i` is accepted, no command is issued while `bus_busy_i` is high. The first message's address phase begins only once it is low.
- R3: A 7-bit address is sent as tx byte {addr[6:0], rd} with command START|WRITE. Command bits are [5] start, [4] stop, [3] read, [2] write, [1] nack, [0] iack, so this command is 6'b100100.
- R4: With the 10-bit flag set, the first byte is 8'hF0 | addr[9:8]<<1 | rd, issued as START|WRITE. A second WRITE (6'b000100) then carries addr[7:0] before any data byte.
- R5: Each write byte is taken from the write stream and issued as one WRITE command with that byte on `tx_data_o`.
- R6: A read message of N bytes issues N-1 READ commands (6'b001000) followed by one READ|NACK (6'b001010). Each received byte appears once on `rd_valid_o`/`rd_data_o`, in order.
- R7: When a non-last message ends, the next message gets a repeated START with a fresh address byte. If its no-start flag is set, its first data command follows immediately, in its own direction.
- R8: After the last message a STOP (6'b010000) is issued, then an IACK (6'b000001). The block then reports `done_o`=1 with `err_o`=0.
- R9: A NACK seen after an address byte or a write byte leads to STOP, then IACK. The block then reports error code 1 (no device).
- R10: Arbitration loss leads to STOP, then IACK. The block then reports error code 2 (retry).
- R11: No command is issued while `tip_i` is high, nor in the cycle right after a command.
- R12: If no command is issued for TIMEOUT_CYC cycles during a transfer, the block returns to idle. It reports `done_o`=1 with error code 4 (timeout) and issues no further command.
- R13: A no-start message with a byte count of 0 is rejected with STOP, then IACK. The block then reports error code 3 (I/O error).
- R14: `done_o` and `err_o` hold their values until the next `start_i`, which clears them to 0. A `start_i` during a transfer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a transfer (accepted when idle) |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer finished, held until next start |
| err_o | output | 3 | Result: 0 none, 1 no device, 2 retry, 3 I/O error, 4 timeout |
| desc_valid_i | input | 1 | Next message descriptor available |
| desc_take_o | output | 1 | Descriptor consumed this cycle |
| desc_addr_i | input | 10 | Slave address |
| desc_rd_i | input | 1 | Message direction is read |
| desc_ten_i | input | 1 | Use 10-bit addressing |
| desc_nostart_i | input | 1 | Continue without repeated START |
| desc_len_i | input | LEN_W | Byte count |
| desc_last_i | input | 1 | Last message of the transfer |
| wr_valid_i | input | 1 | Write byte available |
| wr_data_i | input | 8 | Write byte |
| wr_take_o | output | 1 | Write byte consumed this cycle |
| rd_valid_o | output | 1 | Received byte valid |
| rd_data_o | output | 8 | Received byte |
| cmd_valid_o | output | 1 | Command strobe to the byte master |
| cmd_o | output | 6 | Command bits: start, stop, read, write, nack, iack |
| tx_data_o | output | 8 | Byte to transmit with the command |
| tip_i | input | 1 | Master transfer in progress |
| bus_busy_i | input | 1 | Bus busy |
| nack_i | input | 1 | Last written byte was not acknowledged |
| arb_lost_i | input | 1 | Arbitration lost |
| rx_data_i | input | 8 | Byte received by the master |

## Verification
The hardest situations to reach are the mid-transfer ones. One is a NACK or arbitration loss on one specific byte. Another is a master that never drops its transfer-in-progress flag. The bench models the byte master with a per-test script naming which command index returns NACK or loses arbitration, and a hang switch that keeps `tip_i` high for good. The chained test feeds a read after a write and then a no-start write, so that the repeated-START path and the direction switch without an address are both taken in one transfer.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_INIT, S_ADDR, S_ADDR10, S_START, S_WRITE, S_READ, S_DONE, S_ERROR
  } seq_state_e;

  typedef enum logic [2:0] {
    E_NONE    = 3'd0,
    E_NODEV   = 3'd1,
    E_RETRY   = 3'd2,
    E_IOERR   = 3'd3,
    E_TIMEOUT = 3'd4
  } seq_err_e;

  localparam int CB_READ = 3;
  localparam int CB_NACK = 1;

  localparam logic [5:0] C_START_WR = 6'b100100;
  localparam logic [5:0] C_STOP     = 6'b010000;
  localparam logic [5:0] C_RD       = 6'b001000;
  localparam logic [5:0] C_RD_NACK  = 6'b001010;
  localparam logic [5:0] C_WR       = 6'b000100;
  localparam logic [5:0] C_IACK     = 6'b000001;
endpackage

// File: rtl/i2c_seq_addr_gen.sv
module i2c_seq_addr_gen (
  input  logic [9:0] addr_i,
  input  logic       rd_i,
  input  logic       ten_i,
  output logic [7:0] first_o,
  output logic [7:0] second_o
);
  always_comb begin
    if (ten_i) first_o = {5'b11110, addr_i[9:8], rd_i};
    else       first_o = {addr_i[6:0], rd_i};
    second_o = addr_i[7:0];
  end
endmodule

// File: rtl/i2c_seq_timer.sv
module i2c_seq_timer #(
  parameter int unsigned LIMIT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic kick_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!run_i || kick_i)      cnt_q <= '0;
    else if (cnt_q != LIM)          cnt_q <= cnt_q + CNT_W'(1);
  end

  assign expired_o = run_i && (cnt_q == LIM);

  p_cnt_bound_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);
  p_kick_clears_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> !expired_o);
endmodule

// File: rtl/i2c_msg_sequencer.sv
module i2c_msg_sequencer
  import i2c_seq_pkg::*;
#(
  parameter int unsigned LEN_W       = 8,
  parameter int unsigned TIMEOUT_CYC = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [2:0]       err_o,
  input  logic             desc_valid_i,
  output logic             desc_take_o,
  input  logic [9:0]       desc_addr_i,
  input  logic             desc_rd_i,
  input  logic             desc_ten_i,
  input  logic             desc_nostart_i,
  input  logic [LEN_W-1:0] desc_len_i,
  input  logic             desc_last_i,
  input  logic             wr_valid_i,
  input  logic [7:0]       wr_data_i,
  output logic             wr_take_o,
  output logic             rd_valid_o,
  output logic [7:0]       rd_data_o,
  output logic             cmd_valid_o,
  output logic [5:0]       cmd_o,
  output logic [7:0]       tx_data_o,
  input  logic             tip_i,
  input  logic             bus_busy_i,
  input  logic             nack_i,
  input  logic             arb_lost_i,
  input  logic [7:0]       rx_data_i
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  seq_state_e       state_q, st_d, eff_st;
  seq_err_e         err_q, err_d;
  logic [LEN_W-1:0] pos_q, pos_d, p, eff_len;
  logic [9:0]       cur_addr_q;
  logic             cur_rd_q, cur_ten_q, cur_last_q;
  logic [LEN_W-1:0] cur_len_q;
  logic             done_q, hold_q;
  logic             step, tmo, start_ok, load, fin, ok, go_issue;
  logic [7:0]       addr_first, addr_second;

  i2c_seq_addr_gen u_addr (
    .addr_i   (cur_addr_q),
    .rd_i     (cur_rd_q),
    .ten_i    (cur_ten_q),
    .first_o  (addr_first),
    .second_o (addr_second)
  );

  i2c_seq_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy_o),
    .kick_i    (cmd_valid_o),
    .expired_o (tmo)
  );

  assign busy_o   = (state_q != S_IDLE);
  assign start_ok = start_i && (state_q == S_IDLE);
  assign step     = busy_o && !tip_i && !hold_q && !tmo;

  always_comb begin
    st_d = state_q; err_d = err_q; pos_d = pos_q;
    load = 1'b0; fin = 1'b0; ok = 1'b1; go_issue = 1'b0;
    cmd_valid_o = 1'b0; cmd_o = '0; tx_data_o = '0;
    wr_take_o = 1'b0; rd_valid_o = 1'b0; desc_take_o = 1'b0;
    p = pos_q; eff_len = cur_len_q; eff_st = state_q;
    if (step) begin
      if (state_q == S_DONE || state_q == S_ERROR) begin
        cmd_valid_o = 1'b1; cmd_o = C_IACK; st_d = S_IDLE; fin = 1'b1;
      end else if (arb_lost_i) begin
        cmd_valid_o = 1'b1; cmd_o = C_STOP; st_d = S_ERROR; err_d = E_RETRY;
      end else begin
        unique case (state_q)
          S_INIT: if (!bus_busy_i && desc_valid_i) begin
            desc_take_o = 1'b1; load = 1'b1; pos_d = '0; st_d = S_ADDR;
          end
          S_ADDR: begin
            cmd_valid_o = 1'b1; cmd_o = C_START_WR; tx_data_o = addr_first;
            st_d = cur_ten_q ? S_ADDR10 : S_START;
          end
          S_ADDR10: begin
            if (nack_i) begin
              cmd_valid_o = 1'b1; cmd_o = C_STOP; st_d = S_ERROR; err_d = E_NODEV;
            end else begin
              cmd_valid_o = 1'b1; cmd_o = C_WR; tx_data_o = addr_second; st_d = S_START;
            end
          end
          S_START, S_WRITE, S_READ: begin
            if (state_q != S_READ && nack_i) begin
              cmd_valid_o = 1'b1; cmd_o = C_STOP; st_d = S_ERROR; err_d = E_NODEV;
            end else begin
              go_issue = 1'b1;
              if (state_q == S_READ) begin
                rd_valid_o = 1'b1; p = pos_q + ONE;
              end else begin
                eff_st = cur_rd_q ? S_READ : S_WRITE;
              end
              if (p >= cur_len_q) begin
                go_issue = 1'b0;
                if (cur_last_q) begin
                  cmd_valid_o = 1'b1; cmd_o = C_STOP; st_d = S_DONE;
                end else if (!desc_valid_i) begin
                  ok = 1'b0;
                end else begin
                  desc_take_o = 1'b1; load = 1'b1; p = '0;
                  if (desc_nostart_i && desc_len_i == '0) begin
                    cmd_valid_o = 1'b1; cmd_o = C_STOP; st_d = S_ERROR; err_d = E_IOERR;
                  end else if (!desc_nostart_i) begin
                    st_d = S_ADDR;
                  end else begin
                    go_issue = 1'b1; eff_len = desc_len_i;
                    eff_st = desc_rd_i ? S_READ : S_WRITE;
                  end
                end
              end
              if (ok && go_issue) begin
                if (eff_st == S_READ) begin
                  cmd_valid_o = 1'b1;
                  cmd_o = (p == eff_len - ONE) ? C_RD_NACK : C_RD;
                  st_d = S_READ;
                end else if (wr_valid_i) begin
                  cmd_valid_o = 1'b1; cmd_o = C_WR; tx_data_o = wr_data_i;
                  wr_take_o = 1'b1; p = p + ONE; st_d = S_WRITE;
                end else begin
                  ok = 1'b0;
                end
              end
              pos_d = p;
            end
          end
          default: ;
        endcase
      end
      if (!ok) begin
        st_d = state_q; err_d = err_q; pos_d = pos_q; load = 1'b0;
        cmd_valid_o = 1'b0; cmd_o = '0; tx_data_o = '0;
        wr_take_o = 1'b0; rd_valid_o = 1'b0; desc_take_o = 1'b0;
      end
    end
  end

  assign rd_data_o = rx_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; err_q <= E_NONE; pos_q <= '0; done_q <= 1'b0; hold_q <= 1'b0;
      cur_addr_q <= '0; cur_rd_q <= 1'b0; cur_ten_q <= 1'b0;
      cur_len_q <= '0; cur_last_q <= 1'b0;
    end else begin
      hold_q <= cmd_valid_o;
      if (tmo) begin
        state_q <= S_IDLE; err_q <= E_TIMEOUT; done_q <= 1'b1;
      end else if (start_ok) begin
        state_q <= S_INIT; err_q <= E_NONE; done_q <= 1'b0; pos_q <= '0;
      end else begin
        state_q <= st_d; err_q <= err_d; pos_q <= pos_d;
        if (fin) done_q <= 1'b1;
        if (load) begin
          cur_addr_q <= desc_addr_i; cur_rd_q <= desc_rd_i; cur_ten_q <= desc_ten_i;
          cur_len_q <= desc_len_i; cur_last_q <= desc_last_i;
        end
      end
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;

  p_no_cmd_in_tip_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !tip_i);
  p_cmd_gap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
  p_nack_on_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_o[CB_NACK]) |-> cmd_o[CB_READ]);
  p_done_held_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(err_o)));
  p_fin_after_iack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_o) && err_o != E_TIMEOUT) |-> $past(cmd_valid_o && cmd_o == C_IACK));
  p_wr_take_cmd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_take_o |-> (cmd_valid_o && cmd_o == C_WR));
  p_timeout_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo |=> (!busy_o && done_o && err_o == E_TIMEOUT));
endmodule

// File: tb/tb_i2c_msg_sequencer.sv
module tb_i2c_msg_sequencer;
  localparam int LEN_W = 8;
  localparam int TO    = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start, busy, done, desc_valid, desc_take, wr_valid, wr_take, rd_valid, cmd_valid;
  logic [2:0] err;
  logic [7:0] wr_data, rd_data, tx;
  logic [5:0] cmd;
  logic tip = 0, bbusy = 0, nack = 0, arb = 0;
  logic [7:0] rx = 0;

  logic [9:0] d_addr [8];
  logic       d_rd [8], d_ten [8], d_ns [8], d_last [8];
  logic [7:0] d_len [8];
  int n_desc = 0, didx = 0;
  logic [7:0] wbuf [16];
  int n_wr = 0, widx = 0;

  assign desc_valid = didx < n_desc;
  assign wr_valid   = widx < n_wr;
  assign wr_data    = wbuf[widx[3:0]];

  i2c_msg_sequencer #(.LEN_W(LEN_W), .TIMEOUT_CYC(TO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy), .done_o(done), .err_o(err),
    .desc_valid_i(desc_valid), .desc_take_o(desc_take),
    .desc_addr_i(d_addr[didx[2:0]]), .desc_rd_i(d_rd[didx[2:0]]), .desc_ten_i(d_ten[didx[2:0]]),
    .desc_nostart_i(d_ns[didx[2:0]]), .desc_len_i(d_len[didx[2:0]]), .desc_last_i(d_last[didx[2:0]]),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_take_o(wr_take),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd), .tx_data_o(tx),
    .tip_i(tip), .bus_busy_i(bbusy), .nack_i(nack), .arb_lost_i(arb), .rx_data_i(rx)
  );

  localparam logic [5:0] K_SW = 6'b100100, K_STOP = 6'b010000, K_RD = 6'b001000,
                         K_RDN = 6'b001010, K_WR = 6'b000100, K_IACK = 6'b000001;

  logic [5:0] lc [64];
  logic [7:0] lt [64];
  logic [7:0] rl [16];
  int ncmd = 0, nrd = 0, nrdcmd = 0, viol = 0, cyc = 0, last_cmd_cyc = 0;
  int tip_cnt = 0, nack_at = -1, arb_at = -1;
  bit hang = 0, pend_cmd = 0, pend_desc = 0, pend_wr = 0, prev_cmd = 0;
  logic [5:0] pc;
  logic [7:0] pt;
  int nchk = 0, nfail = 0;

  // byte-master model and monitors: inputs change at negedge, outputs sampled 1 ns later
  always @(negedge clk) begin
    cyc++;
    if (tip_cnt > 0) begin
      tip_cnt--;
      if (tip_cnt == 0 && !hang) tip = 0;
    end
    if (pend_cmd) begin
      if (ncmd < 64) begin lc[ncmd] = pc; lt[ncmd] = pt; end
      tip = 1; tip_cnt = 3;
      nack = (ncmd == nack_at);
      if (ncmd == arb_at) arb = 1;
      if (pc[0]) arb = 0;
      if (pc[3]) begin rx = 8'hC0 + 8'(nrdcmd); nrdcmd++; end
      ncmd++; last_cmd_cyc = cyc;
    end
    if (pend_desc) didx++;
    if (pend_wr) widx++;
    #1;
    pend_cmd = cmd_valid; pc = cmd; pt = tx; pend_desc = desc_take; pend_wr = wr_take;
    if (cmd_valid && (tip || prev_cmd)) viol++;
    prev_cmd = cmd_valid;
    if (rd_valid) begin
      if (nrd < 16) rl[nrd] = rd_data;
      nrd++;
    end
  end

  task automatic ck(input bit c, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!c) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic ck_cmd(input int i, input logic [5:0] c, input logic [7:0] t, input string req);
    ck(lc[i] == c, req, $sformatf("cmd[%0d]", i), lc[i], c);
    if (c == K_SW || c == K_WR) ck(lt[i] == t, req, $sformatf("tx[%0d]", i), lt[i], t);
  endtask

  task automatic add_desc(input logic [9:0] a, input bit r, input bit t, input bit ns,
                          input int len, input bit last);
    d_addr[n_desc] = a; d_rd[n_desc] = r; d_ten[n_desc] = t; d_ns[n_desc] = ns;
    d_len[n_desc] = 8'(len); d_last[n_desc] = last; n_desc++;
  endtask

  task automatic setup();
    @(posedge clk); #1;
    n_desc = 0; didx = 0; n_wr = 0; widx = 0; ncmd = 0; nrd = 0; nrdcmd = 0;
    nack_at = -1; arb_at = -1; hang = 0; tip = 0; tip_cnt = 0; nack = 0; arb = 0;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1; start = 1;
    @(posedge clk); #1; start = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      if (done) break;
    end
  endtask

  task automatic t_reset();
    ck(busy == 0 && done == 0, "R1", "busy/done after reset", {busy, done}, 0);
    ck(err == 0, "R1", "err after reset", err, 0);
    ck(cmd_valid == 0, "R1", "cmd_valid after reset", cmd_valid, 0);
  endtask

  task automatic t_write7();
    setup();
    add_desc(10'h050, 0, 0, 0, 2, 1);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; n_wr = 2;
    pulse_start();
    ck(done == 0 && busy == 1, "R14", "start clears done", done, 0);
    wait_done();
    ck(ncmd == 5, "R8", "command count", ncmd, 5);
    ck_cmd(0, K_SW, 8'hA0, "R3");
    ck_cmd(1, K_WR, 8'h11, "R5");
    ck_cmd(2, K_WR, 8'h22, "R5");
    ck_cmd(3, K_STOP, 0, "R8");
    ck_cmd(4, K_IACK, 0, "R8");
    ck(done == 1 && err == 0, "R8", "done/err", {done, err}, 4'b1000);
    repeat (10) @(negedge clk);
    #1 ck(done == 1 && err == 0, "R14", "done held", {done, err}, 4'b1000);
    ck(busy == 0, "R14", "back to idle", busy, 0);
  endtask

  task automatic t_read7();
    setup();
    add_desc(10'h021, 1, 0, 0, 3, 1);
    pulse_start();
    wait_done();
    ck(ncmd == 6, "R6", "command count", ncmd, 6);
    ck_cmd(0, K_SW, 8'h43, "R3");
    ck_cmd(1, K_RD, 0, "R6");
    ck_cmd(2, K_RD, 0, "R6");
    ck_cmd(3, K_RDN, 0, "R6");
    ck_cmd(4, K_STOP, 0, "R8");
    ck(nrd == 3, "R6", "bytes received", nrd, 3);
    for (int i = 0; i < 3; i++) ck(rl[i] == 8'hC0 + 8'(i), "R6", "rx byte", rl[i], 8'hC0 + i);
    ck(err == 0, "R6", "err", err, 0);
  endtask

  task automatic t_ten();
    setup();
    add_desc(10'h2A5, 0, 1, 0, 1, 1);
    wbuf[0] = 8'h5C; n_wr = 1;
    pulse_start();
    wait_done();
    ck_cmd(0, K_SW, 8'hF4, "R4");
    ck_cmd(1, K_WR, 8'hA5, "R4");
    ck_cmd(2, K_WR, 8'h5C, "R5");
    ck_cmd(3, K_STOP, 0, "R8");
    ck(ncmd == 5 && err == 0, "R4", "count/err", ncmd, 5);
  endtask

  task automatic t_chain();
    setup();
    add_desc(10'h010, 0, 0, 0, 1, 0);
    add_desc(10'h010, 1, 0, 0, 2, 0);
    add_desc(10'h010, 0, 0, 1, 1, 1);
    wbuf[0] = 8'h77; wbuf[1] = 8'h88; n_wr = 2;
    pulse_start();
    wait_done();
    ck(ncmd == 8, "R7", "command count", ncmd, 8);
    ck_cmd(0, K_SW, 8'h20, "R7");
    ck_cmd(1, K_WR, 8'h77, "R7");
    ck_cmd(2, K_SW, 8'h21, "R7");
    ck_cmd(3, K_RD, 0, "R7");
    ck_cmd(4, K_RDN, 0, "R7");
    ck_cmd(5, K_WR, 8'h88, "R7");
    ck_cmd(6, K_STOP, 0, "R7");
    ck(nrd == 2 && err == 0, "R7", "reads/err", nrd, 2);
  endtask

  task automatic t_nack();
    setup();
    add_desc(10'h033, 0, 0, 0, 2, 1);
    wbuf[0] = 8'h01; wbuf[1] = 8'h02; n_wr = 2;
    nack_at = 1;
    pulse_start();
    wait_done();
    ck(ncmd == 4, "R9", "command count", ncmd, 4);
    ck_cmd(2, K_STOP, 0, "R9");
    ck_cmd(3, K_IACK, 0, "R9");
    ck(err == 1, "R9", "err code", err, 1);
    repeat (5) @(negedge clk);
    #1 ck(err == 1 && done == 1, "R14", "err held", err, 1);
  endtask

  task automatic t_arb();
    setup();
    add_desc(10'h044, 1, 0, 0, 3, 1);
    arb_at = 1;
    pulse_start();
    wait_done();
    ck(ncmd == 4, "R10", "command count", ncmd, 4);
    ck_cmd(2, K_STOP, 0, "R10");
    ck(err == 2, "R10", "err code", err, 2);
  endtask

  task automatic t_busy();
    setup();
    bbusy = 1;
    add_desc(10'h012, 0, 0, 0, 0, 1);
    pulse_start();
    repeat (20) @(negedge clk);
    #1 ck(ncmd == 0 && busy == 1, "R2", "no command while bus busy", ncmd, 0);
    bbusy = 0;
    wait_done();
    ck_cmd(0, K_SW, 8'h24, "R2");
    ck(ncmd == 3 && err == 0, "R2", "count after release", ncmd, 3);
  endtask

  task automatic t_timeout();
    setup();
    hang = 1;
    add_desc(10'h055, 0, 0, 0, 1, 1);
    wbuf[0] = 8'h99; n_wr = 1;
    pulse_start();
    wait_done();
    ck(err == 4 && done == 1, "R12", "timeout code", err, 4);
    ck(ncmd == 1, "R12", "commands before abort", ncmd, 1);
    ck(cyc - last_cmd_cyc >= TO - 1 && cyc - last_cmd_cyc <= TO + 3, "R12", "abort delay",
       cyc - last_cmd_cyc, TO);
    repeat (5) @(negedge clk);
    #1 ck(ncmd == 1 && busy == 0, "R12", "no command after abort", ncmd, 1);
  endtask

  task automatic t_ioerr();
    setup();
    add_desc(10'h066, 0, 0, 0, 1, 0);
    add_desc(10'h066, 0, 0, 1, 0, 1);
    wbuf[0] = 8'h3C; n_wr = 1;
    pulse_start();
    wait_done();
    ck(ncmd == 4, "R13", "command count", ncmd, 4);
    ck_cmd(2, K_STOP, 0, "R13");
    ck(err == 3, "R13", "err code", err, 3);
  endtask

  task automatic t_start_ignored();
    setup();
    add_desc(10'h007, 0, 0, 0, 1, 1);
    wbuf[0] = 8'hE1; n_wr = 1;
    pulse_start();
    repeat (3) @(negedge clk);
    pulse_start();
    wait_done();
    ck(ncmd == 4 && err == 0, "R14", "start during transfer ignored", ncmd, 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog all actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    start = 0;
    repeat (4) @(negedge clk);
    #1 t_reset();
    rst_n = 1;
    t_write7();
    t_read7();
    t_ten();
    t_chain();
    t_nack();
    t_arb();
    t_busy();
    t_timeout();
    t_ioerr();
    t_start_ignored();
    ck(viol == 0, "R11", "commands during tip or back-to-back", viol, 0);
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule